// File: doc/BRIEF.md
# Flagged 16-bit ALU with Barrel Shifter

This block is the arithmetic core of a small integer datapath. It takes two operands, a three-bit operation code, a byte/word select and a four-bit shift count. In the same cycle it returns the result. The operations are add, subtract, bitwise AND/OR/XOR, and single-cycle shifts: arithmetic right, logical right and left, by 0 to 15 places.

Alongside the result, the block derives five condition flags: carry, zero, negative, overflow and digit carry. On subtraction, carry and digit carry act as inverted borrows. A status register holds these flags. When the commit input is high at a clock edge, the register takes only the flags that the current operation owns and keeps the others.

In byte mode the operation works on the low eight bits. The flags come from that byte, and the upper byte of the result is a copy of the first operand's upper byte. Reset is asserted asynchronously and released through a two-stage synchronizer.

Top module: `flag_alu`

## Requirements
- R1: Opcode 0 (add) gives `op_a + op_b` at the active width. Carry (status bit 0) is the carry out of the active width. Digit carry (status bit 4) is the carry out of bit 3.
- R2: Opcode 1 (subtract) gives `op_a - op_b`. Carry is 1 when no borrow occurs (`op_a >= op_b` unsigned at the active width). Digit carry is 1 when the low nibble of `op_a` is at least the low nibble of `op_b`.
- R3: Overflow (status bit 3) is set on add when both operands share a sign and the result's sign differs. Subtract uses the same rule with the sign of `op_b` inverted. Logic and shift operations clear overflow.
- R4: Zero (status bit 1) is set when the active-width result is all zeros. Negative (status bit 2) copies the most significant active result bit.
- R5: With `byte_mode` = 1, the operation and all flags use bits 7..0 only, and `result[15:8]` equals `op_a[15:8]`.
- R6: Opcodes 2, 3 and 4 give AND, OR and XOR. They update zero, negative and overflow, and leave carry and digit carry unchanged.
- R7: Opcode 5 (arithmetic right) and opcode 6 (logical right) shift by `shamt`. Carry takes the last bit shifted out. Digit carry is unchanged.
- R8: Opcode 7 (left) shifts by `shamt`, filling with zeros. Carry takes the last bit shifted out past the active width.
- R9: A shift with `shamt` = 0 returns the active operand unchanged and leaves carry unchanged.
- R10: The status register updates only on a clock edge with `commit` = 1. It reads all zeros after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 16 | First operand, also the shift source |
| op_b | input | 16 | Second operand |
| op_code | input | 3 | Operation select (0 add … 7 left shift) |
| byte_mode | input | 1 | 1 selects the 8-bit operation |
| shamt | input | 4 | Shift count |
| commit | input | 1 | Load the owned flags into the status register |
| result | output | 16 | Combinational result |
| status | output | 5 | Registered flags {DC, OV, N, Z, C} |

## Verification
The result is combinational and is due in the same cycle its inputs are applied. The bench drives the inputs on a falling edge and samples `result` one nanosecond later, before the next rising edge. A flag change shows on `status` one rising edge after the commit. The bench therefore compares `status` on the following falling edge with a flag image it keeps for itself. Cycles with commit low check that `status` stays as it was.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0, OP_SUB = 3'd1, OP_AND = 3'd2, OP_OR  = 3'd3,
    OP_XOR = 3'd4, OP_ASR = 3'd5, OP_LSR = 3'd6, OP_SHL = 3'd7
  } alu_op_e;

  localparam int NFLAGS = 5;
  localparam int FL_C  = 0;
  localparam int FL_Z  = 1;
  localparam int FL_N  = 2;
  localparam int FL_OV = 3;
  localparam int FL_DC = 4;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         byte_sel,
  output logic [W-1:0] sum,
  output logic         carry,
  output logic         dcarry,
  output logic         ovf
);
  localparam int HW = W / 2;
  localparam int NB = 4;

  logic [W-1:0]  bx;
  logic [W:0]    full_s;
  logic [HW:0]   half_s;
  logic [NB:0]   nib_s;
  logic          sa, sb, sr;

  always_comb begin
    bx     = sub ? ~b : b;
    full_s = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, sub};
    half_s = {1'b0, a[HW-1:0]} + {1'b0, bx[HW-1:0]} + {{HW{1'b0}}, sub};
    nib_s  = {1'b0, a[NB-1:0]} + {1'b0, bx[NB-1:0]} + {{NB{1'b0}}, sub};
    sum    = full_s[W-1:0];
    carry  = byte_sel ? half_s[HW] : full_s[W];
    dcarry = nib_s[NB];
    sa     = byte_sel ? a[HW-1]      : a[W-1];
    sb     = byte_sel ? bx[HW-1]     : bx[W-1];
    sr     = byte_sel ? full_s[HW-1] : full_s[W-1];
    ovf    = (sa == sb) && (sr != sa);
  end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int W  = 16,
  parameter int CW = $clog2(W)
) (
  input  logic [W-1:0]  a,
  input  logic [1:0]    kind,      // 0 arith right, 1 logical right, 2 left
  input  logic          byte_sel,
  input  logic [CW-1:0] amt,
  output logic [W-1:0]  res,
  output logic          cout
);
  localparam int HW = W / 2;

  logic              fill;
  logic [W-1:0]      ext;
  logic signed [W+1:0] rvec;
  logic [W+1:0]      rsh;
  logic [2*W-1:0]    lsh;
  logic [W-1:0]      lsrc;

  always_comb begin
    fill = (kind == 2'd0) && (byte_sel ? a[HW-1] : a[W-1]);
    ext  = byte_sel ? {{HW{fill}}, a[HW-1:0]} : a;
    rvec = $signed({fill, ext, 1'b0});
    rsh  = rvec >>> amt;
    lsrc = byte_sel ? {{HW{1'b0}}, a[HW-1:0]} : a;
    lsh  = {{W{1'b0}}, lsrc} << amt;
    if (kind == 2'd2) begin
      res  = lsh[W-1:0];
      cout = byte_sel ? lsh[HW] : lsh[W];
    end else begin
      res  = rsh[W:1];
      cout = rsh[0];
    end
  end
endmodule

// File: rtl/alu_status.sv
module alu_status
  import alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [NFLAGS-1:0] upd_mask,
  input  logic [NFLAGS-1:0] flag_val,
  output logic [NFLAGS-1:0] status_q,
  output logic              rst_ok
);
  logic              rst_meta;
  logic [NFLAGS-1:0] status_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ok   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ok   <= rst_meta;
    end
  end

  always_comb begin
    status_d = status_q;
    if (commit) status_d = (status_q & ~upd_mask) | (flag_val & upd_mask);
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) status_q <= '0;
    else         status_q <= status_d;
  end

  // R10: without commit the flags hold
  a_r10_hold_without_commit: assert property (@(posedge clk) disable iff (!rst_ok)
    !commit |=> $stable(status_q));
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import alu_pkg::*;
#(
  parameter int W  = 16,
  parameter int CW = $clog2(W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      op_a,
  input  logic [W-1:0]      op_b,
  input  logic [2:0]        op_code,
  input  logic              byte_mode,
  input  logic [CW-1:0]     shamt,
  input  logic              commit,
  output logic [W-1:0]      result,
  output logic [NFLAGS-1:0] status
);
  localparam int HW = W / 2;

  alu_op_e           op;
  logic [W-1:0]      as_sum, sh_res, core;
  logic              as_c, as_dc, as_ov, sh_c;
  logic              is_arith, is_logic, is_shift;
  logic [1:0]        sh_kind;
  logic [NFLAGS-1:0] upd_mask, flag_val;
  logic              rst_ok;

  assign op = alu_op_e'(op_code);

  alu_addsub #(.W(W)) u_addsub (
    .a(op_a), .b(op_b), .sub(op == OP_SUB), .byte_sel(byte_mode),
    .sum(as_sum), .carry(as_c), .dcarry(as_dc), .ovf(as_ov)
  );

  alu_shift #(.W(W), .CW(CW)) u_shift (
    .a(op_a), .kind(sh_kind), .byte_sel(byte_mode), .amt(shamt),
    .res(sh_res), .cout(sh_c)
  );

  always_comb begin
    is_arith = (op == OP_ADD) || (op == OP_SUB);
    is_shift = (op == OP_ASR) || (op == OP_LSR) || (op == OP_SHL);
    is_logic = !is_arith && !is_shift;
    sh_kind  = (op == OP_ASR) ? 2'd0 : (op == OP_LSR) ? 2'd1 : 2'd2;
    unique case (op)
      OP_AND:  core = op_a & op_b;
      OP_OR:   core = op_a | op_b;
      OP_XOR:  core = op_a ^ op_b;
      OP_ADD, OP_SUB: core = as_sum;
      default: core = sh_res;
    endcase
    result = byte_mode ? {op_a[W-1:HW], core[HW-1:0]} : core;

    flag_val         = '0;
    flag_val[FL_Z]   = byte_mode ? (core[HW-1:0] == '0) : (core == '0);
    flag_val[FL_N]   = byte_mode ? core[HW-1] : core[W-1];
    flag_val[FL_OV]  = is_arith && as_ov;
    flag_val[FL_C]   = is_arith ? as_c : sh_c;
    flag_val[FL_DC]  = as_dc;

    upd_mask         = '0;
    upd_mask[FL_Z]   = 1'b1;
    upd_mask[FL_N]   = 1'b1;
    upd_mask[FL_OV]  = 1'b1;
    upd_mask[FL_C]   = is_arith || (is_shift && (shamt != '0));
    upd_mask[FL_DC]  = is_arith;
  end

  alu_status u_status (
    .clk(clk), .rst_n(rst_n), .commit(commit), .upd_mask(upd_mask),
    .flag_val(flag_val), .status_q(status), .rst_ok(rst_ok)
  );

  // R3: logic and shift operations leave overflow cleared
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_ok)
    (commit && !is_arith) |=> !status[FL_OV]);
  // R4: zero flag follows the active-width result seen at the port
  a_r4_zero_tracks_result: assert property (@(posedge clk) disable iff (!rst_ok)
    commit |=> status[FL_Z] == $past(byte_mode ? (result[HW-1:0] == '0) : (result == '0)));
  // R5: byte mode passes the upper operand byte through
  a_r5_upper_byte_pass: assert property (@(posedge clk) disable iff (!rst_ok)
    byte_mode |-> result[W-1:HW] == op_a[W-1:HW]);
  // R6: non-arithmetic operations keep digit carry
  a_r6_dc_kept: assert property (@(posedge clk) disable iff (!rst_ok)
    (commit && !is_arith) |=> $stable(status[FL_DC]));
  // R9: zero-count shifts keep carry
  a_r9_zero_count_keeps_c: assert property (@(posedge clk) disable iff (!rst_ok)
    (commit && is_shift && shamt == '0) |=> $stable(status[FL_C]));
endmodule

// File: tb/flag_alu_bench.sv
`timescale 1ns/1ps
module flag_alu_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] op_a, op_b;
  logic [2:0]  op_code;
  logic        byte_mode, commit;
  logic [3:0]  shamt;
  logic [15:0] result;
  logic [4:0]  status;

  int checks = 0, errors = 0;
  logic [4:0] model_st;

  always #2 clk = ~clk;  // 250 MHz

  flag_alu u_flag_alu (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_code(op_code),
    .byte_mode(byte_mode), .shamt(shamt), .commit(commit),
    .result(result), .status(status)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [2:0] op, input logic bm);
    if (bm) return "R5";
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2, 3'd3, 3'd4: return "R6";
      3'd7: return "R8";
      default: return "R7";
    endcase
  endfunction

  // bench reference built on integer arithmetic
  task automatic model(input logic [15:0] a, input logic [15:0] b, input logic [2:0] op,
                       input logic bm, input logic [3:0] sh,
                       output logic [15:0] res, output logic [4:0] nst);
    int w, mask, aa, bb, r, sa, sb, sr, sv, c, dc, ov;
    logic [4:0] upd;
    w = bm ? 8 : 16; mask = (1 << w) - 1;
    aa = int'(a) & mask; bb = int'(b) & mask;
    c = 0; dc = 0; ov = 0; r = 0;
    sa = (aa >> (w-1)) & 1; sb = (bb >> (w-1)) & 1;
    upd = 5'b00110 | 5'b01000;  // Z N OV always
    case (op)
      3'd0: begin
        r = (aa + bb) & mask; c = (aa + bb) > mask ? 1 : 0;
        dc = ((aa & 15) + (bb & 15)) > 15 ? 1 : 0;
        sr = (r >> (w-1)) & 1; ov = (sa == sb && sr != sa) ? 1 : 0;
        upd = 5'b11111;
      end
      3'd1: begin
        r = (aa - bb) & mask; c = aa >= bb ? 1 : 0;
        dc = (aa & 15) >= (bb & 15) ? 1 : 0;
        sr = (r >> (w-1)) & 1; ov = (sa != sb && sr != sa) ? 1 : 0;
        upd = 5'b11111;
      end
      3'd2: r = aa & bb;
      3'd3: r = aa | bb;
      3'd4: r = aa ^ bb;
      3'd5: begin
        sv = sa ? aa - (1 << w) : aa;
        r = (sv >>> sh) & mask;
        if (sh != 0) c = (sv >>> (int'(sh) - 1)) & 1;
      end
      3'd6: begin
        r = aa >> sh;
        if (sh != 0) c = (aa >> (int'(sh) - 1)) & 1;
      end
      default: begin
        r = (aa << sh) & mask; c = ((aa << sh) >> w) & 1;
      end
    endcase
    if (op >= 3'd5 && sh != 0) upd[0] = 1'b1;
    res = bm ? {a[15:8], 8'(r)} : 16'(r);
    nst = {dc[0], ov[0], ((r >> (w-1)) & 1) != 0, r == 0, c[0]};
    nst = (model_st & ~upd) | (nst & upd);
  endtask

  task automatic run(input logic [15:0] a, input logic [15:0] b, input logic [2:0] op,
                     input logic bm, input logic [3:0] sh, input logic cm, input string extra);
    logic [15:0] er; logic [4:0] ns;
    @(negedge clk);
    op_a = a; op_b = b; op_code = op; byte_mode = bm; shamt = sh; commit = cm;
    model(a, b, op, bm, sh, er, ns);
    #1;
    check({tag_of(op, bm), " result ", extra}, result, er);
    if (cm) model_st = ns;
    @(negedge clk);
    commit = 1'b0;
    check({"R3 R4 R10 status ", tag_of(op, bm), " ", extra}, {11'd0, status}, {11'd0, model_st});
  endtask

  initial begin
    #150000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    op_a = '0; op_b = '0; op_code = '0; byte_mode = 0; shamt = '0; commit = 0;
    model_st = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R10 reset status", {11'd0, status}, 16'd0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check("R10 status after release", {11'd0, status}, 16'd0);

    run(16'hFFFF, 16'h0001, 3'd0, 0, 0, 1, "R1 wrap carry");
    run(16'h000F, 16'h0001, 3'd0, 0, 0, 1, "R1 digit carry");
    run(16'h7FFF, 16'h0001, 3'd0, 0, 0, 1, "R3 add overflow");
    run(16'h0005, 16'h0005, 3'd1, 0, 0, 1, "R2 equal no borrow");
    run(16'h0010, 16'h0001, 3'd1, 0, 0, 1, "R2 digit borrow");
    run(16'h8000, 16'h0001, 3'd1, 0, 0, 1, "R3 sub overflow");
    run(16'h0000, 16'h0001, 3'd1, 0, 0, 1, "R2 borrow");
    run(16'hAB7F, 16'h0001, 3'd0, 1, 0, 1, "R5 byte overflow");
    run(16'h12FF, 16'h0001, 3'd0, 1, 0, 1, "R5 byte carry zero");
    run(16'hF0F0, 16'h0F0F, 3'd2, 0, 0, 1, "R6 and zero keeps C");
    run(16'h8001, 16'h0000, 3'd5, 0, 4'd15, 1, "R7 asr 15");
    run(16'h8001, 16'h0000, 3'd6, 0, 4'd1, 1, "R7 lsr 1");
    run(16'h0081, 16'h0000, 3'd5, 1, 4'd9, 1, "R7 byte asr beyond");
    run(16'hC000, 16'h0000, 3'd7, 0, 4'd2, 1, "R8 shl carry");
    run(16'h00C0, 16'h0000, 3'd7, 1, 4'd8, 1, "R8 byte shl 8");
    run(16'hFFFF, 16'h0001, 3'd0, 0, 0, 1, "R9 set carry");
    run(16'h1234, 16'h0000, 3'd6, 0, 4'd0, 1, "R9 zero count");
    run(16'h5555, 16'h0000, 3'd7, 0, 4'd0, 1, "R9 zero count left");
    run(16'h0000, 16'h0000, 3'd1, 0, 0, 0, "R10 no commit");

    for (int i = 0; i < 400; i++)
      run(16'($urandom), 16'($urandom), 3'($urandom), 1'($urandom),
          4'($urandom), ($urandom % 4) != 0, "random");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule